// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block produces every divided output clock of a system clock generator from one internal timing clock. It stops and restarts groups of those clocks in response to three active-low, asynchronous control pins. One pin freezes the processor clocks and the 66 MHz group. One pin freezes the bus (PCI) clocks but leaves a single free-running PCI lane untouched. The third pin powers the clock sources down, which forces every output low. Each control pin is brought into the timing-clock domain through a two-flop synchronizer. A group's gate enable can change only on a cycle where that group's clock stays low. Because of this, no output ever shows a shortened high pulse or a shortened low phase on the way into a stop or out of one.

Latency is counted in rising edges of the free-running PCI lane. When power-down is released, the source-enable output returns at once. A lock timer then counts rising edges of the internal reference divider and holds every output low until it expires. This timer stands in for the oscillator and PLL settle time, which in silicon is several milliseconds. Its length is a parameter.

Each group is a divide-by-N counter followed by a gate. All dividers restart together, so every group's first rising edge after lock lines up. The gated PCI lanes stay in phase with the free-running lane.

Top module: `clk_stop_ctrl`

## Requirements
- R1: During reset, and after reset is released, `osc_en_o` is high and every clock output is low. The outputs stay low for at least (LOCK_REF_EDGES-1)*DIV_REF timing-clock cycles after reset.
- R2: While running, each group produces exactly one rising edge every DIV_x timing-clock cycles. The groups and their ratios are processor (DIV_CPU), 66 MHz (DIV_MID), PCI (DIV_PCI), APIC (DIV_APIC), reference (DIV_REF) and USB (DIV_USB). All lanes of one group carry identical values.
- R3: While `cpu_stop_ni` is low, `cpu_clk_o` and `mid_clk_o` are static low within 5 + DIV_MID/2 cycles. The APIC, reference, USB and PCI outputs keep running.
- R4: While `pci_stop_ni` is low, lanes 1 and up of `pci_clk_o` are static low within 5 + DIV_PCI/2 cycles. Lane 0 (the free-running lane) and the processor group keep running.
- R5: When a stop pin changes, the affected group reaches its new state by the second rising edge of `pci_clk_o[0]`. A stopped group shows no rising edge after that point. A restarted group gives its first rising edge no later than that point.
- R6: Every high pulse of every output lasts exactly DIV_x/2 timing-clock cycles. This includes the last pulse before a stop and the first pulse after a restart.
- R7: Every rising edge of a gated PCI lane falls in the same cycle as a rising edge of `pci_clk_o[0]`.
- R8: While `pwr_dn_ni` is low, `osc_en_o` falls and every output is low within 6 + (largest DIV_x)/2 cycles; with the default ratios this is within two PCI periods. `pci_clk_o[0]` shows at most two further rising edges in that time. The stop pins have no effect while power-down is held.
- R9: After `pwr_dn_ni` returns high, `osc_en_o` is high within four cycles. All outputs then stay low for at least (LOCK_REF_EDGES-1)*DIV_REF cycles, after which every group runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal timing clock all groups are divided from |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Asynchronous; low stops processor and 66 MHz groups |
| pci_stop_ni | input | 1 | Asynchronous; low stops the gated PCI lanes |
| pwr_dn_ni | input | 1 | Asynchronous; low powers down all sources and outputs |
| osc_en_o | output | 1 | High while oscillator and VCOs are to run |
| cpu_clk_o | output | N_CPU | Processor clock lanes |
| mid_clk_o | output | N_MID | 66 MHz clock lanes |
| pci_clk_o | output | N_PCI | PCI lanes; lane 0 is free-running |
| apic_clk_o | output | N_APIC | APIC clock lanes |
| ref_clk_o | output | N_REF | Reference clock lanes |
| usb_clk_o | output | 1 | USB clock |

## Verification
The checker's latency windows rest on one assumption: a control pin that is low is sampled low on every edge it is counted. Any high sample restarts the window, so the assertions assume a pin that goes low stays low for the whole window it is judged over. They also assume the default divide ratios are even. The bench drives the control pins half a clock away from the sampling edge and holds each level for many PCI periods before it judges the outputs. Power-down is released only after the drain has finished, so each assertion window opens and closes on stable pin levels.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  typedef enum logic [1:0] {
    PH_LOCK  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2,
    PH_OFF   = 2'd3
  } phase_e;

  localparam int GRP_CPU  = 0;
  localparam int GRP_MID  = 1;
  localparam int GRP_PCIF = 2;
  localparam int GRP_PCIG = 3;
  localparam int GRP_APIC = 4;
  localparam int GRP_REF  = 5;
  localparam int GRP_USB  = 6;
  localparam int NUM_GRP  = 7;

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/ckg_div.sv
module ckg_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic lvl_nxt_o
);

  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)                      cnt_d = CW'(DIV - 1);
    else if (cnt_q == CW'(DIV - 1))  cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  assign lvl_nxt_o = run_i && (cnt_d < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CW'(DIV - 1);
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_nxt_i,
  input  logic want_i,
  output logic clk_o,
  output logic en_o
);

  logic en_q, en_d, out_q;

  // enable may only move on a cycle whose next level is low
  assign en_d = lvl_nxt_i ? en_q : want_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= lvl_nxt_i & en_d;
    end
  end

  assign clk_o = out_q;
  assign en_o  = en_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import ckg_pkg::*;
#(
  parameter int N_CPU          = 6,
  parameter int N_MID          = 2,
  parameter int N_PCI          = 6,
  parameter int N_APIC         = 3,
  parameter int N_REF          = 2,
  parameter int DIV_CPU        = 2,
  parameter int DIV_MID        = 4,
  parameter int DIV_PCI        = 8,
  parameter int DIV_APIC       = 16,
  parameter int DIV_REF        = 10,
  parameter int DIV_USB        = 6,
  parameter int LOCK_REF_EDGES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_stop_ni,
  input  logic              pci_stop_ni,
  input  logic              pwr_dn_ni,
  output logic              osc_en_o,
  output logic [N_CPU-1:0]  cpu_clk_o,
  output logic [N_MID-1:0]  mid_clk_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_APIC-1:0] apic_clk_o,
  output logic [N_REF-1:0]  ref_clk_o,
  output logic              usb_clk_o
);

  localparam int LCW = $clog2(LOCK_REF_EDGES + 1);

  logic [2:0] ctl_s;
  logic       cpu_go, pci_go, pd_go;

  ckg_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_dn_ni, pci_stop_ni, cpu_stop_ni}),
    .q_o    (ctl_s)
  );

  assign cpu_go = ctl_s[0];
  assign pci_go = ctl_s[1];
  assign pd_go  = ctl_s[2];

  phase_e         ph_q, ph_d;
  logic [LCW-1:0] lock_q, lock_d;
  logic           src_run, run_ok, ref_prev_q, ref_rise;

  logic [NUM_GRP-1:0] lvl_nxt, want, en, gclk;

  assign src_run = (ph_q != PH_OFF);
  assign run_ok  = (ph_q == PH_RUN);

  always_comb begin
    want           = {NUM_GRP{run_ok}};
    want[GRP_CPU]  = run_ok & cpu_go;
    want[GRP_MID]  = run_ok & cpu_go;
    want[GRP_PCIG] = run_ok & pci_go;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int D = (g == GRP_CPU)  ? DIV_CPU  :
                       (g == GRP_MID)  ? DIV_MID  :
                       (g == GRP_PCIF) ? DIV_PCI  :
                       (g == GRP_PCIG) ? DIV_PCI  :
                       (g == GRP_APIC) ? DIV_APIC :
                       (g == GRP_REF)  ? DIV_REF  : DIV_USB;

    ckg_div #(.DIV(D)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (src_run),
      .lvl_nxt_o (lvl_nxt[g])
    );

    ckg_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_nxt_i (lvl_nxt[g]),
      .want_i    (want[g]),
      .clk_o     (gclk[g]),
      .en_o      (en[g])
    );
  end

  // lock timer ticks on rising edges of the internal reference divider
  assign ref_rise = lvl_nxt[GRP_REF] & ~ref_prev_q;

  always_comb begin
    ph_d   = ph_q;
    lock_d = lock_q;
    unique case (ph_q)
      PH_LOCK: begin
        if (!pd_go) begin
          ph_d   = PH_OFF;
          lock_d = '0;
        end else if (ref_rise) begin
          if (lock_q == LCW'(LOCK_REF_EDGES - 1)) begin
            ph_d   = PH_RUN;
            lock_d = '0;
          end else begin
            lock_d = lock_q + 1'b1;
          end
        end
      end
      PH_RUN:   if (!pd_go)    ph_d = PH_DRAIN;
      PH_DRAIN: if (en == '0)  ph_d = PH_OFF;
      PH_OFF: begin
        lock_d = '0;
        if (pd_go) ph_d = PH_LOCK;
      end
      default:  ph_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_LOCK;
      lock_q     <= '0;
      ref_prev_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      lock_q     <= lock_d;
      ref_prev_q <= lvl_nxt[GRP_REF];
    end
  end

  assign osc_en_o                = src_run;
  assign cpu_clk_o               = {N_CPU{gclk[GRP_CPU]}};
  assign mid_clk_o               = {N_MID{gclk[GRP_MID]}};
  assign pci_clk_o[0]            = gclk[GRP_PCIF];
  assign pci_clk_o[N_PCI-1:1]    = {(N_PCI-1){gclk[GRP_PCIG]}};
  assign apic_clk_o              = {N_APIC{gclk[GRP_APIC]}};
  assign ref_clk_o               = {N_REF{gclk[GRP_REF]}};
  assign usb_clk_o               = gclk[GRP_USB];

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int N_CPU    = 6,
  parameter int N_MID    = 2,
  parameter int N_PCI    = 6,
  parameter int N_APIC   = 3,
  parameter int N_REF    = 2,
  parameter int DIV_CPU  = 2,
  parameter int DIV_MID  = 4,
  parameter int DIV_PCI  = 8,
  parameter int DIV_APIC = 16,
  parameter int DIV_REF  = 10,
  parameter int DIV_USB  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_stop_ni,
  input logic              pci_stop_ni,
  input logic              pwr_dn_ni,
  input logic              osc_en_o,
  input logic [N_CPU-1:0]  cpu_clk_o,
  input logic [N_MID-1:0]  mid_clk_o,
  input logic [N_PCI-1:0]  pci_clk_o,
  input logic [N_APIC-1:0] apic_clk_o,
  input logic [N_REF-1:0]  ref_clk_o,
  input logic              usb_clk_o
);

  function automatic int max_div();
    int m;
    m = DIV_CPU;
    if (DIV_MID  > m) m = DIV_MID;
    if (DIV_PCI  > m) m = DIV_PCI;
    if (DIV_APIC > m) m = DIV_APIC;
    if (DIV_REF  > m) m = DIV_REF;
    if (DIV_USB  > m) m = DIV_USB;
    return m;
  endfunction

  localparam int CPU_WIN = 5 + DIV_MID / 2;
  localparam int PCI_WIN = 5 + DIV_PCI / 2;
  localparam int PD_WIN  = 6 + max_div() / 2;

  logic [15:0] cpu_lo_n, pci_lo_n, pd_lo_n;
  logic [7:0]  hi_pci, hi_cpu, hi_apic;
  logic        all_low;

  assign all_low = (cpu_clk_o == '0) && (mid_clk_o == '0) && (pci_clk_o == '0) &&
                   (apic_clk_o == '0) && (ref_clk_o == '0) && !usb_clk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_lo_n <= '0;
      pci_lo_n <= '0;
      pd_lo_n  <= '0;
      hi_pci   <= '0;
      hi_cpu   <= '0;
      hi_apic  <= '0;
    end else begin
      cpu_lo_n <= cpu_stop_ni ? '0 : ((&cpu_lo_n) ? cpu_lo_n : cpu_lo_n + 1'b1);
      pci_lo_n <= pci_stop_ni ? '0 : ((&pci_lo_n) ? pci_lo_n : pci_lo_n + 1'b1);
      pd_lo_n  <= pwr_dn_ni   ? '0 : ((&pd_lo_n)  ? pd_lo_n  : pd_lo_n  + 1'b1);
      hi_pci   <= pci_clk_o[0]  ? hi_pci  + 1'b1 : '0;
      hi_cpu   <= cpu_clk_o[0]  ? hi_cpu  + 1'b1 : '0;
      hi_apic  <= apic_clk_o[0] ? hi_apic + 1'b1 : '0;
    end
  end

  AST_CPU_GROUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_lo_n >= 16'(CPU_WIN)) |-> (cpu_clk_o == '0 && mid_clk_o == '0)); // R3

  AST_PCI_GATED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_lo_n >= 16'(PCI_WIN)) |-> (pci_clk_o[N_PCI-1:1] == '0)); // R4

  AST_PWRDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_lo_n >= 16'(PD_WIN)) |-> (all_low && !osc_en_o)); // R8

  AST_SRC_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> all_low); // R8

  AST_PCI_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_clk_o[1]) |-> $rose(pci_clk_o[0])); // R7

  AST_PCI_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pci_clk_o[0]) |-> (hi_pci == 8'(DIV_PCI / 2))); // R6

  AST_CPU_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_clk_o[0]) |-> (hi_cpu == 8'(DIV_CPU / 2))); // R6

  AST_APIC_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(apic_clk_o[0]) |-> (hi_apic == 8'(DIV_APIC / 2))); // R6

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_CPU(N_CPU), .N_MID(N_MID), .N_PCI(N_PCI), .N_APIC(N_APIC), .N_REF(N_REF),
  .DIV_CPU(DIV_CPU), .DIV_MID(DIV_MID), .DIV_PCI(DIV_PCI), .DIV_APIC(DIV_APIC),
  .DIV_REF(DIV_REF), .DIV_USB(DIV_USB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_stop_ni(cpu_stop_ni), .pci_stop_ni(pci_stop_ni),
  .pwr_dn_ni(pwr_dn_ni), .osc_en_o(osc_en_o), .cpu_clk_o(cpu_clk_o), .mid_clk_o(mid_clk_o),
  .pci_clk_o(pci_clk_o), .apic_clk_o(apic_clk_o), .ref_clk_o(ref_clk_o), .usb_clk_o(usb_clk_o)
);

// File: tb/clk_stop_ctrl_bench.sv
module clk_stop_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N_CPU = 6, N_MID = 2, N_PCI = 6, N_APIC = 3, N_REF = 2;
  localparam int DIV_CPU = 2, DIV_MID = 4, DIV_PCI = 8, DIV_APIC = 16;
  localparam int DIV_REF = 10, DIV_USB = 6, LOCK = 8;
  localparam int NG = 7, WIN = 240;
  // group bit order: 0 cpu, 1 mid, 2 free pci, 3 gated pci, 4 apic, 5 ref, 6 usb
  localparam int GC = 0, GM = 1, GPF = 2, GPG = 3;

  // {cpu_stop_n, pci_stop_n, running-group mask}
  localparam logic [8:0] VEC [5] = '{
    {1'b1, 1'b1, 7'b1111111},
    {1'b0, 1'b1, 7'b1111100},
    {1'b1, 1'b0, 7'b1110111},
    {1'b0, 1'b0, 7'b1110100},
    {1'b1, 1'b1, 7'b1111111}
  };

  logic clk = 1'b0, rst_n = 1'b0, cpu_n = 1'b1, pci_n = 1'b1, pd_n = 1'b1;
  logic              osc_en, usb;
  logic [N_CPU-1:0]  cpu;
  logic [N_MID-1:0]  mid;
  logic [N_PCI-1:0]  pci;
  logic [N_APIC-1:0] apic;
  logic [N_REF-1:0]  refc;

  always #2.5 clk = ~clk;

  clk_stop_ctrl #(
    .N_CPU(N_CPU), .N_MID(N_MID), .N_PCI(N_PCI), .N_APIC(N_APIC), .N_REF(N_REF),
    .DIV_CPU(DIV_CPU), .DIV_MID(DIV_MID), .DIV_PCI(DIV_PCI), .DIV_APIC(DIV_APIC),
    .DIV_REF(DIV_REF), .DIV_USB(DIV_USB), .LOCK_REF_EDGES(LOCK)
  ) u_clk_stop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cpu_stop_ni(cpu_n), .pci_stop_ni(pci_n),
    .pwr_dn_ni(pd_n), .osc_en_o(osc_en), .cpu_clk_o(cpu), .mid_clk_o(mid),
    .pci_clk_o(pci), .apic_clk_o(apic), .ref_clk_o(refc), .usb_clk_o(usb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int rises [NG];
  int hi_run [NG];
  int width_err = 0, align_err = 0, lane_err = 0;
  logic [NG-1:0] prev_s = '0, cur_s;

  function automatic int div_of(int g);
    case (g)
      0: return DIV_CPU;
      1: return DIV_MID;
      2, 3: return DIV_PCI;
      4: return DIV_APIC;
      5: return DIV_REF;
      default: return DIV_USB;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_rises();
    for (int g = 0; g < NG; g++) rises[g] = 0;
  endtask

  function automatic int sum_rises();
    int s = 0;
    for (int g = 0; g < NG; g++) s += rises[g];
    return s;
  endfunction

  function automatic bit outs_low();
    return (cpu == '0) && (mid == '0) && (pci == '0) && (apic == '0) && (refc == '0) && !usb;
  endfunction

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    cur_s = {usb, refc[0], apic[0], pci[1], pci[0], mid[0], cpu[0]};
    for (int g = 0; g < NG; g++) begin
      if (cur_s[g] && !prev_s[g]) rises[g]++;
      if (cur_s[g]) hi_run[g]++;
      else begin
        if (prev_s[g] && hi_run[g] != div_of(g) / 2) width_err++;
        hi_run[g] = 0;
      end
    end
    if (cur_s[GPG] && !prev_s[GPG] && !(cur_s[GPF] && !prev_s[GPF])) align_err++;
    if ((cpu != '0 && cpu != '1) || (mid != '0 && mid != '1) ||
        (apic != '0 && apic != '1) || (refc != '0 && refc != '1) ||
        (pci[N_PCI-1:1] != '0 && pci[N_PCI-1:1] != '1)) lane_err++;
    prev_s = cur_s;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rec;
    string tag;
    for (int g = 0; g < NG; g++) begin
      rises[g] = 0;
      hi_run[g] = 0;
    end

    // R1: reset state
    tick(5);
    check(outs_low(), "R1 outputs low in reset", int'(cpu[0]), 0);
    check(osc_en == 1'b1, "R1 source enabled in reset", int'(osc_en), 1);
    rst_n = 1'b1;
    clear_rises();
    tick((LOCK - 1) * DIV_REF - 5);
    check(sum_rises() == 0, "R1 outputs held low during lock", sum_rises(), 0);
    check(osc_en == 1'b1, "R1 source enabled after reset", int'(osc_en), 1);
    tick(120);

    // R2 R3 R4: table of stop patterns
    for (int v = 0; v < 5; v++) begin
      cpu_n = VEC[v][8];
      pci_n = VEC[v][7];
      tick(40);
      clear_rises();
      tick(WIN);
      for (int g = 0; g < NG; g++) begin
        if (g == GC || g == GM) tag = "R3";
        else if (g == GPG)      tag = "R4";
        else if (!VEC[v][8])    tag = "R3";
        else if (!VEC[v][7] && g != GPF) tag = "R2";
        else if (!VEC[v][7])    tag = "R4";
        else                    tag = "R2";
        check(rises[g] == (VEC[v][g] ? WIN / div_of(g) : 0),
              $sformatf("%s vector %0d group %0d", tag, v, g),
              rises[g], VEC[v][g] ? WIN / div_of(g) : 0);
      end
    end

    // R5: PCI stop latency
    pci_n = 1'b0;
    clear_rises();
    for (int i = 0; i < 64 && rises[GPF] < 2; i++) tick(1);
    clear_rises();
    tick(3 * DIV_PCI);
    check(rises[GPG] == 0, "R5 gated PCI quiet after second free edge", rises[GPG], 0);
    check(rises[GPF] == 3, "R4 free PCI keeps running", rises[GPF], 3);
    pci_n = 1'b1;
    clear_rises();
    rec = -1;
    for (int i = 0; i < 64 && rec < 0; i++) begin
      tick(1);
      if (rises[GPG] > 0) rec = rises[GPF];
    end
    check(rec >= 1 && rec <= 2, "R5 gated PCI restart by second free edge", rec, 2);

    // R5: CPU stop latency
    tick(20);
    cpu_n = 1'b0;
    clear_rises();
    for (int i = 0; i < 64 && rises[GPF] < 2; i++) tick(1);
    clear_rises();
    tick(3 * DIV_PCI);
    check(rises[GC] + rises[GM] == 0, "R5 CPU group quiet after second free edge",
          rises[GC] + rises[GM], 0);
    cpu_n = 1'b1;
    clear_rises();
    rec = -1;
    for (int i = 0; i < 64 && rec < 0; i++) begin
      tick(1);
      if (rises[GC] > 0) rec = rises[GPF];
    end
    check(rec >= 0 && rec <= 2, "R5 CPU restart by second free edge", rec, 2);
    tick(40);

    // R6 R7 R2: monitor results so far
    check(width_err == 0, "R6 high pulse widths", width_err, 0);
    check(align_err == 0, "R7 gated PCI edges aligned", align_err, 0);
    check(lane_err == 0, "R2 lanes identical", lane_err, 0);

    // R8: power-down
    pd_n = 1'b0;
    clear_rises();
    tick(2 * DIV_PCI);
    check(rises[GPF] <= 2, "R8 free PCI edges after power-down", rises[GPF], 2);
    check(outs_low(), "R8 all outputs low", int'(pci[0]), 0);
    check(osc_en == 1'b0, "R8 source disabled", int'(osc_en), 0);
    clear_rises();
    cpu_n = 1'b0;
    tick(20);
    pci_n = 1'b0;
    tick(20);
    cpu_n = 1'b1;
    pci_n = 1'b1;
    tick(20);
    check(sum_rises() == 0, "R8 stop pins ignored in power-down", sum_rises(), 0);
    check(osc_en == 1'b0, "R8 source stays off", int'(osc_en), 0);

    // R9: restart
    pd_n = 1'b1;
    tick(4);
    check(osc_en == 1'b1, "R9 source re-enabled", int'(osc_en), 1);
    clear_rises();
    tick((LOCK - 1) * DIV_REF - 8);
    check(sum_rises() == 0, "R9 outputs low during relock", sum_rises(), 0);
    tick(120);
    for (int g = 0; g < NG; g++)
      check(rises[g] > 0, $sformatf("R9 group %0d running after relock", g), rises[g], 1);
    clear_rises();
    tick(WIN);
    check(rises[GPF] == WIN / DIV_PCI, "R2 free PCI rate after relock", rises[GPF], WIN / DIV_PCI);
    check(width_err == 0, "R6 high pulse widths across power-down", width_err, 0);
    check(align_err == 0, "R7 alignment across power-down", align_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule